// File: doc/BRIEF.md
# Split Set/Clear Control-Status Register

This block holds the function-enable state of a counting front end in one 32-bit register word. There is no way to load that state directly. The write word carries two halves that act on the same functions. A 1 in a bit of the lower half switches the matching function on. A 1 in the bit sixteen places higher switches it off. A 0 in either half leaves the function as it was. Because of this, software can change one function without first reading the word back.

A read does not return the last written word. It returns the live function states in the lower half and four status flags from elsewhere in the chip in the upper half.

The register also steers pulses into the counter channels. Channel 1 has index 0. Three kinds of pulse are routed:

- the 25 MHz test pulses;
- single test pulses issued by software;
- the reference pulser.

Each injected pulse leaves the block one clock after its input strobe, as a per-channel one-cycle pulse. The bus decode and the counters are outside this block.

The read port is a plain request/response pair. `rd_req` is always accepted. `rd_valid` follows one clock later with the data. There is no back-pressure.

Top module: `csr_setclr_top`

## Requirements
- R1: A write with bit n set and bit n+16 clear (n one of the implemented functions 0, 4, 5, 6) turns function n on; `func_en[n]` shows it from the clock edge that samples `wr_en`.
- R2: A write with bit n+16 set and bit n clear turns function n off at that same edge.
- R3: A 0 in both bit n and bit n+16 of a write leaves function n unchanged, and cycles without `wr_en` change no function.
- R4: When bit n and bit n+16 are both 1 in one write, function n toggles.
- R5: Function bits other than 0 (user LED), 4 (test-pulse enable), 5 (counter test mode) and 6 (reference pulser to channel 1) ignore writes, stay 0 on `func_en` and read back as 0.
- R6: After reset every function is off, `inj_pulse` is 0, and a read returns 0 when all status inputs are low.
- R7: `rd_req` in a cycle gives `rd_valid` one clock later, with bits 15:0 equal to the function states before any write in the request cycle.
- R8: Read bit 16 reports `sts_scaler_en`, bit 18 `sts_mcs_en`, bit 24 `sts_armed` and bit 27 `sts_overflow`. All other upper bits read 0.
- R9: A `tp_strobe` reaches channel c only while functions 4 and 5 are both on and `tp_mask[c]` is 0; with either function off, no channel receives it.
- R10: While function 5 is on, a `sw_pulse` reaches every channel whose `ch_inhibit` bit is 0; while it is off, `sw_pulse` reaches no channel.
- R11: A `ref_strobe` reaches channel index 0 only, and only while function 6 is on and function 5 is off.
- R12: A channel with `ch_inhibit` set receives no injected pulse of any kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write word: set half 15:0, clear half 31:16 |
| rd_req | input | 1 | Read request, always accepted |
| rd_valid | output | 1 | Read data valid, one clock after the request |
| rd_data | output | 32 | Registered read word |
| sts_scaler_en | input | 1 | Scaler-enabled status |
| sts_mcs_en | input | 1 | Multiscaler-enabled status |
| sts_armed | input | 1 | Armed status |
| sts_overflow | input | 1 | Counter overflow status |
| func_en | output | 16 | Function enable states |
| tp_strobe | input | 1 | One 25 MHz test-pulse strobe |
| sw_pulse | input | 1 | Software single test pulse |
| ref_strobe | input | 1 | One reference-pulser strobe |
| tp_mask | input | NUM_CH | 1 excludes the channel from 25 MHz test pulses |
| ch_inhibit | input | NUM_CH | 1 blocks every injected pulse to the channel |
| inj_pulse | output | NUM_CH | Registered injected pulse per channel |

## Verification
The bench aims at the write encodings that differ only in which half carries the 1:

- set only;
- clear only;
- both halves, which toggles;
- neither half.

A design that gave priority to set or to clear, or that stored the raw word, would read back the wrong lower half.

It writes every unimplemented bit to catch a register that keeps state there. It raises all status inputs to catch flags that land on neighbouring bits.

On the pulse side it enables the 25 MHz test pulses without counter test mode, and it fires the reference pulser with test mode on. A router that used a single enable, or that let the pulser win on channel 1, would then inject pulses where none belong. It also sets mask and inhibit bits on chosen channels to expose a router that applied them to the wrong pulse kind.

// File: rtl/csr_pkg.sv
package csr_pkg;
  localparam int unsigned CSR_W  = 32;
  localparam int unsigned HALF_W = CSR_W / 2;

  // Function positions within the set half (clear is +HALF_W)
  localparam int unsigned F_LED    = 0;
  localparam int unsigned F_TPULSE = 4;
  localparam int unsigned F_CTEST  = 5;
  localparam int unsigned F_REFP   = 6;

  localparam logic [HALF_W-1:0] IMPL_MASK =
    HALF_W'((1 << F_LED) | (1 << F_TPULSE) | (1 << F_CTEST) | (1 << F_REFP));

  // Status positions in the read word
  localparam int unsigned S_SCALER = 16;
  localparam int unsigned S_MCS    = 18;
  localparam int unsigned S_ARMED  = 24;
  localparam int unsigned S_OVF    = 27;

  localparam logic [CSR_W-1:0] RD_DEFINED =
    {{HALF_W{1'b0}}, IMPL_MASK} |
    (CSR_W'(1) << S_SCALER) | (CSR_W'(1) << S_MCS) |
    (CSR_W'(1) << S_ARMED)  | (CSR_W'(1) << S_OVF);

  // Next state of one set/clear pair; both set toggles
  function automatic logic pair_next(input logic cur, input logic set_b,
                                     input logic clr_b);
    unique case ({set_b, clr_b})
      2'b10:   return 1'b1;
      2'b01:   return 1'b0;
      2'b11:   return ~cur;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/csr_bit_cell.sv
module csr_bit_cell #(
  parameter bit IMPL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic set_b,
  input  logic clr_b,
  output logic state
);
  generate
    if (IMPL) begin : g_flop
      logic q;
      always_ff @(posedge clk) begin
        if (!rst_n)     q <= 1'b0;
        else if (wr_en) q <= csr_pkg::pair_next(q, set_b, clr_b);
      end
      assign state = q;
    end else begin : g_tie
      logic unused_in;
      assign unused_in = wr_en ^ set_b ^ clr_b ^ clk ^ rst_n;
      assign state = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/csr_readback.sv
module csr_readback
  import csr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req,
  input  logic [HALF_W-1:0] func_en,
  input  logic              sts_scaler_en,
  input  logic              sts_mcs_en,
  input  logic              sts_armed,
  input  logic              sts_overflow,
  output logic              rd_valid,
  output logic [CSR_W-1:0]  rd_data
);
  logic [CSR_W-1:0] word;

  always_comb begin
    word = '0;
    word[HALF_W-1:0] = func_en & IMPL_MASK;
    word[S_SCALER]   = sts_scaler_en;
    word[S_MCS]      = sts_mcs_en;
    word[S_ARMED]    = sts_armed;
    word[S_OVF]      = sts_overflow;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rd_req) rd_data <= word;
    end
  end
endmodule

// File: rtl/pulse_route.sv
module pulse_route #(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tp_on,
  input  logic              test_mode,
  input  logic              ref_on,
  input  logic              tp_strobe,
  input  logic              sw_pulse,
  input  logic              ref_strobe,
  input  logic [NUM_CH-1:0] tp_mask,
  input  logic [NUM_CH-1:0] ch_inhibit,
  output logic [NUM_CH-1:0] inj_pulse
);
  logic tp_go, sw_go, ref_go;
  assign tp_go  = tp_on & tp_strobe;
  assign sw_go  = test_mode & sw_pulse;
  assign ref_go = ref_on & ~test_mode & ref_strobe;

  genvar c;
  generate
    for (c = 0; c < NUM_CH; c++) begin : g_ch
      logic hit;
      if (c == 0) begin : g_first
        assign hit = (tp_go & ~tp_mask[c]) | sw_go | ref_go;
      end else begin : g_rest
        assign hit = (tp_go & ~tp_mask[c]) | sw_go;
      end
      always_ff @(posedge clk) begin
        if (!rst_n) inj_pulse[c] <= 1'b0;
        else        inj_pulse[c] <= hit & ~ch_inhibit[c];
      end
    end
  endgenerate
endmodule

// File: rtl/csr_setclr_top.sv
module csr_setclr_top
  import csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  input  logic              rd_req,
  output logic              rd_valid,
  output logic [31:0]       rd_data,
  input  logic              sts_scaler_en,
  input  logic              sts_mcs_en,
  input  logic              sts_armed,
  input  logic              sts_overflow,
  output logic [15:0]       func_en,
  input  logic              tp_strobe,
  input  logic              sw_pulse,
  input  logic              ref_strobe,
  input  logic [NUM_CH-1:0] tp_mask,
  input  logic [NUM_CH-1:0] ch_inhibit,
  output logic [NUM_CH-1:0] inj_pulse
);
  logic [HALF_W-1:0] set_half, clr_half;
  assign set_half = wr_data[HALF_W-1:0];
  assign clr_half = wr_data[CSR_W-1:HALF_W];

  genvar n;
  generate
    for (n = 0; n < HALF_W; n++) begin : g_fn
      csr_bit_cell #(.IMPL(IMPL_MASK[n])) u_cell (
        .clk  (clk),
        .rst_n(rst_n),
        .wr_en(wr_en),
        .set_b(set_half[n]),
        .clr_b(clr_half[n]),
        .state(func_en[n])
      );
    end
  endgenerate

  csr_readback u_rb (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req       (rd_req),
    .func_en      (func_en),
    .sts_scaler_en(sts_scaler_en),
    .sts_mcs_en   (sts_mcs_en),
    .sts_armed    (sts_armed),
    .sts_overflow (sts_overflow),
    .rd_valid     (rd_valid),
    .rd_data      (rd_data)
  );

  pulse_route #(.NUM_CH(NUM_CH)) u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .tp_on     (func_en[F_TPULSE] & func_en[F_CTEST]),
    .test_mode (func_en[F_CTEST]),
    .ref_on    (func_en[F_REFP]),
    .tp_strobe (tp_strobe),
    .sw_pulse  (sw_pulse),
    .ref_strobe(ref_strobe),
    .tp_mask   (tp_mask),
    .ch_inhibit(ch_inhibit),
    .inj_pulse (inj_pulse)
  );
endmodule

// File: rtl/csr_setclr_sva.sv
module csr_setclr_sva
  import csr_pkg::*;
#(
  parameter int unsigned NUM_CH = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [31:0]       wr_data,
  input logic              rd_req,
  input logic              rd_valid,
  input logic [31:0]       rd_data,
  input logic [15:0]       func_en,
  input logic              tp_strobe,
  input logic              sw_pulse,
  input logic              ref_strobe,
  input logic [NUM_CH-1:0] inj_pulse
);
  logic [15:0] set_only, clr_only, both;
  assign set_only = wr_data[15:0] & ~wr_data[31:16] & IMPL_MASK;
  assign clr_only = ~wr_data[15:0] & wr_data[31:16];
  assign both     = wr_data[15:0] & wr_data[31:16] & IMPL_MASK;

  assert_set_on_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((func_en & $past(set_only)) == $past(set_only)));

  assert_clear_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((func_en & $past(clr_only)) == 16'h0));

  assert_idle_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(func_en));

  assert_both_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ((func_en & $past(both)) == (~$past(func_en) & $past(both))));

  assert_unimpl_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (func_en & ~IMPL_MASK) == 16'h0);

  assert_read_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> (rd_valid && rd_data[15:0] == $past(func_en)));

  assert_read_undefined_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ((rd_data & ~RD_DEFINED) == 32'h0));

  assert_no_test_pulses_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !func_en[F_CTEST] |=> (inj_pulse[NUM_CH-1:1] == '0));

  assert_ref_blocked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (func_en[F_CTEST] && !tp_strobe && !sw_pulse) |=> !inj_pulse[0]);

  assert_ref_one_channel_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!tp_strobe && !sw_pulse && ref_strobe) |=> $countones(inj_pulse) <= 1);
endmodule

bind csr_setclr_top csr_setclr_sva #(.NUM_CH(NUM_CH)) u_sva (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_req    (rd_req),
  .rd_valid  (rd_valid),
  .rd_data   (rd_data),
  .func_en   (func_en),
  .tp_strobe (tp_strobe),
  .sw_pulse  (sw_pulse),
  .ref_strobe(ref_strobe),
  .inj_pulse (inj_pulse)
);

// File: tb/tb_csr_setclr_top.sv
`timescale 1ns/1ps
module tb_csr_setclr_top;
  localparam int unsigned NUM_CH = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic rd_req = 1'b0;
  logic rd_valid;
  logic [31:0] rd_data;
  logic sts_scaler_en = 1'b0, sts_mcs_en = 1'b0, sts_armed = 1'b0, sts_overflow = 1'b0;
  logic [15:0] func_en;
  logic tp_strobe = 1'b0, sw_pulse = 1'b0, ref_strobe = 1'b0;
  logic [NUM_CH-1:0] tp_mask = '0, ch_inhibit = '0;
  logic [NUM_CH-1:0] inj_pulse;

  always #2 clk = ~clk;

  csr_setclr_top #(.NUM_CH(NUM_CH)) dut (.*);

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [15:0] model = '0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  localparam logic [15:0] IMPL = 16'h0071;

  function automatic logic [31:0] rd_expect();
    logic [31:0] w = '0;
    w[15:0] = model & IMPL;
    w[16] = sts_scaler_en; w[18] = sts_mcs_en;
    w[24] = sts_armed;     w[27] = sts_overflow;
    return w;
  endfunction

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(logic [31:0] d, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d;
    for (int n = 0; n < 16; n++) begin
      if (IMPL[n]) begin
        if (d[n] && d[n+16])  model[n] = ~model[n];
        else if (d[n])        model[n] = 1'b1;
        else if (d[n+16])     model[n] = 1'b0;
      end
    end
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
    check(tag, 64'(func_en), 64'(model));
  endtask

  task automatic do_read(string tag);
    @(negedge clk);
    rd_req = 1'b1;
    exp_q.push_back(rd_expect());
    tag_q.push_back(tag);
    @(negedge clk);
    rd_req = 1'b0;
    @(negedge clk);
  endtask

  // Monitor: pop expected read words as the design returns them
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 actual=%0h expected=none", rd_data);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        check(t, 64'(rd_data), 64'(e));
      end
    end
  end

  task automatic pulse_case(logic tp, logic sw, logic rf, logic [NUM_CH-1:0] msk,
                            logic [NUM_CH-1:0] inh, string tag);
    logic [NUM_CH-1:0] e;
    e = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (tp && model[4] && model[5] && !msk[c]) e[c] = 1'b1;
      if (sw && model[5]) e[c] = 1'b1;
      if (c == 0 && rf && model[6] && !model[5]) e[c] = 1'b1;
      if (inh[c]) e[c] = 1'b0;
    end
    @(negedge clk);
    tp_strobe = tp; sw_pulse = sw; ref_strobe = rf; tp_mask = msk; ch_inhibit = inh;
    @(negedge clk);
    tp_strobe = 1'b0; sw_pulse = 1'b0; ref_strobe = 1'b0;
    check(tag, 64'(inj_pulse), 64'(e));
    @(negedge clk);
    check({tag, " idle"}, 64'(inj_pulse), 64'(0));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R6 reset func_en", 64'(func_en), 64'(0));
    check("R6 reset inj_pulse", 64'(inj_pulse), 64'(0));
    do_read("R6 reset read");

    do_write(32'h0000_0001, "R1 set led");
    do_read("R7 read led");
    do_write(32'h0000_0070, "R1 set 4 5 6");
    do_read("R7 read 0x71");
    do_write(32'h0010_0000, "R2 clear tpulse");
    do_write(32'h0000_0000, "R3 zero write");
    do_write(32'h0041_0041, "R4 toggle 0 and 6");
    do_read("R4 read after toggle");
    do_write(32'h0041_0041, "R4 toggle back");
    do_write(32'h0000_FF8E, "R5 unimpl set");
    do_read("R5 unimpl read");
    do_write(32'hFF8E_0000, "R5 unimpl clear");

    sts_scaler_en = 1'b1; sts_mcs_en = 1'b1; sts_armed = 1'b1; sts_overflow = 1'b1;
    do_read("R8 all status");
    sts_mcs_en = 1'b0; sts_overflow = 1'b0;
    do_read("R8 partial status");
    sts_scaler_en = 1'b0; sts_armed = 1'b0;

    // model now: 0x61 (led, ctest, refp)
    pulse_case(1'b1, 1'b0, 1'b0, '0, '0, "R9 tpulse off");
    do_write(32'h0000_0010, "R1 set tpulse");
    pulse_case(1'b1, 1'b0, 1'b0, 32'h0000_0F01, '0, "R9 tpulse mask");
    pulse_case(1'b1, 1'b0, 1'b0, '0, 32'h8000_0002, "R12 tpulse inhibit");
    pulse_case(1'b0, 1'b1, 1'b0, 32'hFFFF_FFFF, 32'h0000_00F0, "R10 sw pulse");
    pulse_case(1'b0, 1'b0, 1'b1, '0, '0, "R11 ref blocked test");
    do_write(32'h0030_0000, "R2 clear test bits");
    pulse_case(1'b1, 1'b0, 1'b0, '0, '0, "R9 no test mode");
    pulse_case(1'b0, 1'b1, 1'b0, '0, '0, "R10 sw without test");
    pulse_case(1'b0, 1'b0, 1'b1, '0, '0, "R11 ref ch1");
    pulse_case(1'b0, 1'b0, 1'b1, '0, 32'h0000_0001, "R12 ref inhibit");
    do_write(32'h0040_0000, "R2 clear refp");
    pulse_case(1'b0, 1'b0, 1'b1, '0, '0, "R11 ref off");

    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R7 actual=%0d expected=0 pending reads", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule